// File: doc/BRIEF.md
# DRAM Refresh and Start-Up Sequencer

This block brings an asynchronous EDO DRAM out of power-up and then keeps it refreshed. After reset it waits out a power-on settling delay. It then runs a burst of wake-up refresh cycles and raises a ready flag. While ready is high, it schedules one refresh at a fixed interval, derived from the clock frequency, so that every row is refreshed within the retention period of the memory.

Each refresh uses the CAS-before-RAS method. The memory supplies the row from its own internal counter, so the block drives no address, and write enable, output enable and the data pins are left to the access controller. The block shares the strobes with that controller. It raises `req_o`, waits for `grant_i`, and then drives RAS and all four byte CAS lines for one cycle, while `bus_own_o` marks when its strobe values are valid.

Refreshes that the controller does not grant are queued. If the queue is already at its limit when the next refresh falls due, the block treats the retention deadline as missed. It drops ready, throws away the queued work and repeats the wake-up burst.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is held, `ready_o`=0, `req_o`=0, `bus_own_o`=0, `ras_n_o`=1 and `cas_n_o`=4'b1111.
- R2: For the first CLK_MHZ*PWRUP_US clock cycles after reset is released, `req_o` stays low and no strobe goes low. `req_o` rises no later than one cycle after that.
- R3: Once the power-up delay has elapsed, exactly WAKE_CYCLES refresh cycles are issued, and `ready_o` then rises. No other strobe activity comes between them.
- R4: In each refresh cycle, all four CAS lines fall together at least ceil(5 ns) of cycles before RAS falls. They stay low for as long as RAS is low. The CAS lines never take mixed values.
- R5: RAS stays low for at least ceil(28 ns) of cycles in each refresh cycle. It stays high for at least ceil(17 ns) of cycles between refresh cycles.
- R6: `bus_own_o` is high in every cycle in which RAS or any CAS line is low.
- R7: While `ready_o` is high and every request is granted, exactly one refresh is issued per CLK_MHZ*REFI_NS/1000 cycles.
- R8: A refresh cycle begins only on a clock edge at which `grant_i` is high. While `grant_i` is low, `req_o` stays high and no strobe moves.
- R9: Refreshes that fall due while the grant is withheld are counted, up to MISS_LIMIT. They are issued back to back once the grant arrives, and `ready_o` stays high throughout.
- R10: If a refresh falls due while MISS_LIMIT refreshes are already pending, then in the next cycle `ready_o` goes low and `req_o` is high. The pending count is discarded, and WAKE_CYCLES refresh cycles are issued before `ready_o` rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| grant_i | input | 1 | Strobe bus granted by the access controller |
| req_o | output | 1 | Request for the strobe bus |
| ready_o | output | 1 | Memory is initialised and its contents are retained |
| bus_own_o | output | 1 | The strobe outputs of this block are valid and must drive the memory |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 4 | Byte column strobes, active low, all moved together |

## Verification
The bench builds the block with CLK_MHZ=100, PWRUP_US=20, REFI_NS=15000, WAKE_CYCLES=8 and MISS_LIMIT=2. This gives a 2000-cycle power-up delay and a 1500-cycle refresh interval. At 100 MHz each timing minimum maps to more than one clock for RAS low (3) and RAS high (2), so the width checks have cycles they can fail on. Because the miss limit is 2, the third refresh that falls due without a grant forces a re-wake. This lets both the backlog path and the deadline-miss path be reached within a few intervals of withheld grant.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_PRECH
  } cbr_ph_e;

  typedef enum logic [1:0] {
    SQ_PWRUP,
    SQ_WAKE,
    SQ_RUN
  } seq_st_e;

  // round a time in ns up to whole clocks, at least one
  function automatic int ns_to_cyc(int ns, int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/rfsh_down_cnt.sv
module rfsh_down_cnt #(
  parameter int RELOAD = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic load_i,
  output logic zero_o
);

  localparam int W = $clog2(RELOAD + 2);

  logic [W-1:0] cnt_q;

  assign zero_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= W'(RELOAD);
    else if (load_i || (en_i && zero_o)) cnt_q <= W'(RELOAD);
    else if (en_i)                    cnt_q <= cnt_q - 1'b1;
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= W'(RELOAD)); // R7

endmodule

// File: rtl/rfsh_pend_ctr.sv
module rfsh_pend_ctr #(
  parameter int LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  input  logic dec_i,
  output logic nz_o,
  output logic miss_o
);

  localparam int W = $clog2(LIMIT + 2);

  logic [W-1:0] cnt_q;

  assign nz_o   = (cnt_q != '0);
  assign miss_o = inc_i && (cnt_q == W'(LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || miss_o)   cnt_q <= '0;
    else if (inc_i && !dec_i)   cnt_q <= cnt_q + 1'b1;
    else if (dec_i && !inc_i)   cnt_q <= cnt_q - 1'b1;
  end

  AST_PEND_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= W'(LIMIT)); // R9
  AST_PEND_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !clr_i) |-> (nz_o || inc_i)); // R9

endmodule

// File: rtl/rfsh_cbr_engine.sv
module rfsh_cbr_engine
  import dram_rfsh_pkg::*;
#(
  parameter int CSR_CYC = 1,
  parameter int RAS_CYC = 3,
  parameter int RP_CYC  = 2,
  parameter int NCAS    = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            ras_n_o,
  output logic [NCAS-1:0] cas_n_o
);

  localparam int MAXC = (CSR_CYC > RAS_CYC) ? ((CSR_CYC > RP_CYC) ? CSR_CYC : RP_CYC)
                                            : ((RAS_CYC > RP_CYC) ? RAS_CYC : RP_CYC);
  localparam int PW   = $clog2(MAXC + 1);

  cbr_ph_e        ph_q, ph_d;
  logic [PW-1:0]  cnt_q, cnt_d;
  logic           ras_q;
  logic [NCAS-1:0] cas_q;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    unique case (ph_q)
      PH_IDLE:
        if (start_i) begin
          ph_d  = PH_SETUP;
          cnt_d = PW'(CSR_CYC - 1);
        end
      PH_SETUP:
        if (cnt_q == '0) begin
          ph_d  = PH_STROBE;
          cnt_d = PW'(RAS_CYC - 1);
        end else cnt_d = cnt_q - 1'b1;
      PH_STROBE:
        if (cnt_q == '0) begin
          ph_d  = PH_PRECH;
          cnt_d = PW'(RP_CYC - 1);
        end else cnt_d = cnt_q - 1'b1;
      PH_PRECH:
        if (cnt_q == '0) ph_d = PH_IDLE;
        else             cnt_d = cnt_q - 1'b1;
      default: ph_d = PH_IDLE;
    endcase
  end

  // strobes registered from next phase: glitch-free pins, aligned with ph_q
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      ras_q <= 1'b1;
      cas_q <= '1;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      ras_q <= (ph_d != PH_STROBE);
      cas_q <= (ph_d == PH_SETUP || ph_d == PH_STROBE) ? '0 : '1;
    end
  end

  assign busy_o  = (ph_q != PH_IDLE);
  assign done_o  = (ph_q == PH_PRECH) && (cnt_q == '0);
  assign ras_n_o = ras_q;
  assign cas_n_o = cas_q;

  AST_CAS_LEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (cas_n_o == '0) && ($past(cas_n_o) == '0)); // R4
  AST_CAS_UNIFORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_n_o == '0) || (cas_n_o == '1)); // R4
  AST_CAS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_n_o |-> (cas_n_o == '0)); // R4

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_rfsh_pkg::*;
#(
  parameter int CLK_MHZ     = 100,
  parameter int PWRUP_US    = 200,
  parameter int REFI_NS     = 15000,
  parameter int WAKE_CYCLES = 8,
  parameter int MISS_LIMIT  = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       grant_i,
  output logic       req_o,
  output logic       ready_o,
  output logic       bus_own_o,
  output logic       ras_n_o,
  output logic [3:0] cas_n_o
);

  localparam int NCAS      = 4;
  localparam int PWRUP_CYC = CLK_MHZ * PWRUP_US;
  localparam int REFI_CYC  = CLK_MHZ * REFI_NS / 1000;
  localparam int CSR_CYC   = ns_to_cyc(5, CLK_MHZ);
  localparam int RAS_CYC   = ns_to_cyc(28, CLK_MHZ);
  localparam int RP_CYC    = ns_to_cyc(17, CLK_MHZ);
  localparam int WW        = $clog2(WAKE_CYCLES + 1);

  seq_st_e       st_q;
  logic [WW-1:0] wake_left_q;
  logic          ready_q;
  logic          pw_zero, refi_zero, tick;
  logic          pend_nz, miss;
  logic          busy, done, cbr_start, wake_done;

  rfsh_down_cnt #(.RELOAD(PWRUP_CYC - 1)) u_pwrup_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (st_q == SQ_PWRUP),
    .load_i (1'b0),
    .zero_o (pw_zero)
  );

  rfsh_down_cnt #(.RELOAD(REFI_CYC - 1)) u_refi_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (st_q == SQ_RUN),
    .load_i (wake_done),
    .zero_o (refi_zero)
  );

  assign tick = (st_q == SQ_RUN) && refi_zero;

  rfsh_pend_ctr #(.LIMIT(MISS_LIMIT)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (st_q != SQ_RUN),
    .inc_i  (tick),
    .dec_i  (done && (st_q == SQ_RUN)),
    .nz_o   (pend_nz),
    .miss_o (miss)
  );

  rfsh_cbr_engine #(
    .CSR_CYC (CSR_CYC),
    .RAS_CYC (RAS_CYC),
    .RP_CYC  (RP_CYC),
    .NCAS    (NCAS)
  ) u_cbr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cbr_start),
    .busy_o  (busy),
    .done_o  (done),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o)
  );

  assign cbr_start = grant_i && !busy &&
                     (((st_q == SQ_WAKE) && (wake_left_q != '0)) ||
                      ((st_q == SQ_RUN) && pend_nz && !miss));
  assign wake_done = (st_q == SQ_WAKE) && done && (wake_left_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= SQ_PWRUP;
      wake_left_q <= '0;
      ready_q     <= 1'b0;
    end else begin
      unique case (st_q)
        SQ_PWRUP:
          if (pw_zero) begin
            st_q        <= SQ_WAKE;
            wake_left_q <= WW'(WAKE_CYCLES);
          end
        SQ_WAKE: begin
          if (cbr_start) wake_left_q <= wake_left_q - 1'b1;
          if (wake_done) begin
            st_q    <= SQ_RUN;
            ready_q <= 1'b1;
          end
        end
        SQ_RUN:
          if (miss) begin
            st_q        <= SQ_WAKE;
            wake_left_q <= WW'(WAKE_CYCLES);
            ready_q     <= 1'b0;
          end
        default: st_q <= SQ_PWRUP;
      endcase
    end
  end

  assign req_o = ((st_q == SQ_WAKE) && ((wake_left_q != '0) || busy)) ||
                 ((st_q == SQ_RUN) && (pend_nz || busy));
  assign ready_o   = ready_q;
  assign bus_own_o = busy;

  AST_QUIET_PWRUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SQ_PWRUP) |-> (!req_o && ras_n_o && (cas_n_o == '1))); // R2
  AST_READY_AFTER_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> ($past(st_q) == SQ_WAKE) && ras_n_o); // R3
  AST_BUS_OWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o || (cas_n_o != '1)) |-> bus_own_o); // R6
  AST_GRANTED_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_own_o) |-> $past(grant_i)); // R8
  AST_MISS_REWAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss |=> (!ready_o && req_o)); // R10

endmodule

// File: tb/dram_refresh_seq_bench.sv
`timescale 1ns/1ps
module dram_refresh_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_MHZ    = 100;
  localparam int PWRUP_US   = 20;
  localparam int REFI_NS    = 15000;
  localparam int WAKE_N     = 8;
  localparam int MISS_LIM   = 2;
  localparam int PWRUP_CYC  = CLK_MHZ * PWRUP_US;
  localparam int REFI_CYC   = CLK_MHZ * REFI_NS / 1000;
  localparam int CSR_MIN    = 1;
  localparam int RAS_MIN    = 3;
  localparam int RP_MIN     = 2;
  localparam int WD_CYCLES  = 150000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       grant_i = 1'b0;
  logic       req_o, ready_o, bus_own_o, ras_n_o;
  logic [3:0] cas_n_o;

  int n_chk = 0;
  int n_fail = 0;
  bit grant_en = 1'b0;
  bit mon_on = 1'b0;
  int ras_falls = 0;
  int v_r4 = 0, v_r5 = 0, v_r6 = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dram_refresh_seq #(
    .CLK_MHZ(CLK_MHZ), .PWRUP_US(PWRUP_US), .REFI_NS(REFI_NS),
    .WAKE_CYCLES(WAKE_N), .MISS_LIMIT(MISS_LIM)
  ) u_dram_refresh_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .grant_i(grant_i), .req_o(req_o),
    .ready_o(ready_o), .bus_own_o(bus_own_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o)
  );

  // arbiter model: grant follows request when enabled
  initial forever begin
    @(negedge clk_i);
    grant_i = grant_en && req_o;
  end

  // strobe monitor
  initial begin
    logic pr;
    int lo, hi, csl;
    bit seen_rise;
    pr = 1'b1; lo = 0; hi = 0; csl = 0; seen_rise = 1'b0;
    forever begin
      @(negedge clk_i);
      if (mon_on) begin
        if (cas_n_o != 4'h0 && cas_n_o != 4'hF) v_r4++;
        if ((!ras_n_o || cas_n_o != 4'hF) && !bus_own_o) v_r6++;
        if (pr && !ras_n_o) begin
          ras_falls++;
          if (csl < CSR_MIN || cas_n_o != 4'h0) v_r4++;
          if (seen_rise && hi < RP_MIN) v_r5++;
          lo = 0;
        end
        if (!pr && ras_n_o) begin
          if (lo < RAS_MIN) v_r5++;
          seen_rise = 1'b1;
          hi = 0;
        end
        if (!ras_n_o) begin
          lo++;
          if (cas_n_o != 4'h0) v_r4++;
        end else hi++;
        csl = (ras_n_o && cas_n_o == 4'h0) ? csl + 1 : 0;
        pr = ras_n_o;
      end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cycles(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wait_fall(int limit);
    int n0 = ras_falls;
    for (int i = 0; i < limit && ras_falls == n0; i++) @(negedge clk_i);
  endtask

  task automatic t_reset_and_init();
    int cnt, n0;
    grant_en = 1'b0;
    rst_ni = 1'b0;
    wait_cycles(4);
    chk(!ready_o && !req_o && !bus_own_o && ras_n_o && cas_n_o == 4'hF, "R1",
        "reset outputs", {ready_o, req_o, bus_own_o, ras_n_o, cas_n_o}, 8'h1F);
    mon_on = 1'b1;
    rst_ni = 1'b1;
    cnt = 0;
    n0 = ras_falls;
    for (int i = 0; i < PWRUP_CYC + 10 && !req_o; i++) begin
      @(negedge clk_i);
      cnt++;
    end
    chk(cnt >= PWRUP_CYC && cnt <= PWRUP_CYC + 1, "R2", "cycles to first request", cnt, PWRUP_CYC);
    chk(ras_falls == n0, "R2", "strobes during power-up", ras_falls - n0, 0);
    // grant withheld: nothing moves
    wait_cycles(40);
    chk(req_o && ras_n_o && ras_falls == n0, "R8", "no cycle without grant", ras_falls - n0, 0);
    grant_en = 1'b1;
    for (int i = 0; i < 500 && !ready_o; i++) @(negedge clk_i);
    chk(ready_o, "R3", "ready after wake burst", ready_o, 1);
    chk(ras_falls - n0 == WAKE_N, "R3", "wake cycles before ready", ras_falls - n0, WAKE_N);
  endtask

  task automatic t_rate();
    int n0;
    wait_fall(2 * REFI_CYC);
    wait_cycles(REFI_CYC / 2);
    n0 = ras_falls;
    wait_cycles(10 * REFI_CYC);
    chk(ras_falls - n0 == 10, "R7", "refreshes in ten intervals", ras_falls - n0, 10);
    chk(ready_o, "R7", "ready held while refreshing", ready_o, 1);
  endtask

  task automatic t_backlog();
    int n0;
    wait_fall(2 * REFI_CYC);
    wait_cycles(REFI_CYC / 2);
    grant_en = 1'b0;
    n0 = ras_falls;
    wait_cycles(2 * REFI_CYC);
    chk(ras_falls == n0, "R8", "no refresh while grant low", ras_falls - n0, 0);
    chk(req_o, "R8", "request held while grant low", req_o, 1);
    chk(ready_o, "R9", "ready with backlog under limit", ready_o, 1);
    grant_en = 1'b1;
    wait_cycles(REFI_CYC / 4);
    chk(ras_falls - n0 == 2, "R9", "queued refreshes issued", ras_falls - n0, 2);
    chk(ready_o && !req_o, "R9", "ready kept, request cleared", {ready_o, req_o}, 2);
  endtask

  task automatic t_miss();
    int n0, n1;
    wait_fall(2 * REFI_CYC);
    wait_cycles(REFI_CYC / 2);
    grant_en = 1'b0;
    n0 = ras_falls;
    wait_cycles(3 * REFI_CYC);
    chk(!ready_o, "R10", "ready dropped on missed deadline", ready_o, 0);
    chk(req_o && ras_falls == n0, "R10", "re-wake requested, nothing issued", ras_falls - n0, 0);
    grant_en = 1'b1;
    for (int i = 0; i < 500 && !ready_o; i++) @(negedge clk_i);
    chk(ready_o, "R10", "ready restored after re-wake", ready_o, 1);
    chk(ras_falls - n0 == WAKE_N, "R10", "re-wake cycle count", ras_falls - n0, WAKE_N);
    n1 = ras_falls;
    wait_cycles(REFI_CYC / 2);
    chk(ras_falls == n1, "R10", "pending discarded after re-wake", ras_falls - n1, 0);
  endtask

  task automatic t_strobe_rules();
    chk(v_r4 == 0, "R4", "CAS-before-RAS violations", v_r4, 0);
    chk(v_r5 == 0, "R5", "RAS width violations", v_r5, 0);
    chk(v_r6 == 0, "R6", "strobe without bus ownership", v_r6, 0);
  endtask

  initial begin
    t_reset_and_init();
    t_rate();
    t_backlog();
    t_miss();
    t_rate();
    t_strobe_rules();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", WD_CYCLES, WD_CYCLES);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule